// File: doc/BRIEF.md
# Sequential Signed Integer Divider

This block divides one signed two's-complement integer by another over several clock cycles and returns a signed quotient and a signed remainder. A caller pulses `start` with both operands while the block is idle. The block latches the operands and turns each one into an unsigned magnitude. It then runs a shift-and-subtract restoring loop on a double-width working register, which yields one quotient bit per cycle. When the loop ends, one further cycle applies the sign rules and registers the results. `done` then pulses for a single cycle.

The quotient truncates toward zero and is negated when the operand signs differ. The remainder carries the sign of the dividend. A zero divisor does not stop the machine. It raises a flag and produces a fixed, defined result. The results stay on the outputs until the next operation completes.

Top module: `sdiv_top`

## Requirements
- R1: While reset is held, and straight after it, `busy`, `done` and `div_by_zero` are low and `quotient` and `remainder` are zero.
- R2: A `start` sampled high on a rising edge while `busy` is low is accepted, and `busy` is high from that edge. With the default WIDTH of 32, `done` rises on the edge WIDTH+1 edges later. `busy` is low from that same edge, and `done` and `busy` are never high together.
- R3: For a non-negative dividend and a positive divisor, the quotient is the floor of dividend/divisor, and the remainder is dividend minus quotient times divisor. The remainder is always smaller than the divisor.
- R4: The quotient magnitude is |dividend| / |divisor| truncated toward zero. It is negated when exactly one operand is negative. For example, 7 / -2 gives -3 and -7 / 2 gives -3.
- R5: A non-zero remainder has the sign of the dividend, and its magnitude is below |divisor|. For example, 7 / -2 leaves 1, -7 / 2 leaves -1 and -7 / -2 leaves -1.
- R6: The most negative dividend is divided through its unsigned magnitude 2^(WIDTH-1). Dividing it by -1 wraps the quotient back to the most negative value and leaves remainder 0.
- R7: With a zero divisor, `div_by_zero` is 1, `quotient` is all ones and `remainder` equals the dividend. With any other divisor, `div_by_zero` is 0.
- R8: A `start` raised while `busy` is high is ignored. The running operation finishes on its original schedule with its original operands.
- R9: `done` is high for exactly one cycle per operation. `quotient`, `remainder` and `div_by_zero` change only on the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a division; accepted only while idle |
| dividend | input | WIDTH | Signed dividend, sampled with an accepted start |
| divisor | input | WIDTH | Signed divisor, sampled with an accepted start |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: the results were just updated |
| quotient | output | WIDTH | Signed quotient |
| remainder | output | WIDTH | Signed remainder |
| div_by_zero | output | 1 | The last operation had a zero divisor |

## Verification
The four sign combinations of 7 and 2 show whether the quotient negation depends on the signs differing and whether the remainder follows the dividend rather than the divisor. Operands equal to or next to the most negative value, including division by -1 and by 1, expose a magnitude path that would sign-extend the value or overflow it. Zero divisors of both dividend signs separate the forced result from a result the loop happened to leave. A few hundred mixed-magnitude pseudo-random pairs check the quotient bits across every loop position, against a bench model that tracks the handshake and the held outputs on every cycle. A start pulse injected mid-operation shows whether a busy unit can be restarted.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
package sdiv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } sdiv_state_e;
endpackage

// File: rtl/sdiv_mag.sv
`timescale 1ns/1ps
// Two's-complement magnitude: invert and add one when the sign bit is set.
// The most negative input maps to 2^(WIDTH-1) read as unsigned.
module sdiv_mag #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] val,
   output logic [WIDTH-1:0] mag,
   output logic             neg
);
   assign neg = val[WIDTH-1];
   assign mag = neg ? (~val + WIDTH'(1)) : val;
endmodule

// File: rtl/sdiv_step.sv
`timescale 1ns/1ps
// One restoring iteration on the double-width working register.
// The trial difference uses WIDTH+1 bits, so the bit shifted out of the
// upper half still takes part in the comparison.
module sdiv_step #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [2*WIDTH-1:0] rem_in,
   input  logic [WIDTH-1:0]   dmag,
   output logic [2*WIDTH-1:0] rem_out
);
   localparam int unsigned RW = 2 * WIDTH;

   logic [WIDTH:0] trial;

   assign trial = rem_in[RW-1:WIDTH-1] - {1'b0, dmag};

   always_comb begin
      if (trial[WIDTH]) begin
         // negative: restoring means keeping the shifted value, quotient bit 0
         rem_out = {rem_in[RW-2:0], 1'b0};
      end else begin
         rem_out = {trial[WIDTH-1:0], rem_in[WIDTH-2:0], 1'b1};
      end
   end
endmodule

// File: rtl/sdiv_fix.sv
`timescale 1ns/1ps
// Sign fix-up of the unsigned results, plus the zero-divisor override.
module sdiv_fix #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] qmag,
   input  logic [WIDTH-1:0] rmag,
   input  logic             q_neg,
   input  logic             r_neg,
   input  logic             zero_div,
   input  logic [WIDTH-1:0] num,
   output logic [WIDTH-1:0] q_out,
   output logic [WIDTH-1:0] r_out
);
   always_comb begin
      if (zero_div) begin
         q_out = '1;
         r_out = num;
      end else begin
         q_out = q_neg ? (~qmag + WIDTH'(1)) : qmag;
         r_out = r_neg ? (~rmag + WIDTH'(1)) : rmag;
      end
   end
endmodule

// File: rtl/sdiv_top.sv
`timescale 1ns/1ps
module sdiv_top
   import sdiv_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] quotient,
   output logic [WIDTH-1:0] remainder,
   output logic             div_by_zero
);
   localparam int unsigned RW = 2 * WIDTH;
   localparam int unsigned CW = $clog2(WIDTH + 1);

   generate
      if (WIDTH < 2) begin : g_width_bad
         $error("sdiv_top: WIDTH must be at least 2");
      end
   endgenerate

   sdiv_state_e      state_q;
   logic [CW-1:0]    cnt_q;
   logic [RW-1:0]    rem_q;
   logic [RW-1:0]    rem_nx;
   logic [WIDTH-1:0] dmag_q;
   logic [WIDTH-1:0] num_q;
   logic             qneg_q, rneg_q, dz_q;
   logic             done_q, dz_out_q;
   logic [WIDTH-1:0] quot_q, remd_q;

   logic [WIDTH-1:0] a_mag, d_mag, q_fix, r_fix;
   logic             a_neg, d_neg;

   sdiv_mag #(.WIDTH(WIDTH)) u_mag_a (.val(dividend), .mag(a_mag), .neg(a_neg));
   sdiv_mag #(.WIDTH(WIDTH)) u_mag_d (.val(divisor),  .mag(d_mag), .neg(d_neg));

   sdiv_step #(.WIDTH(WIDTH)) u_step (
      .rem_in (rem_q),
      .dmag   (dmag_q),
      .rem_out(rem_nx)
   );

   sdiv_fix #(.WIDTH(WIDTH)) u_fix (
      .qmag    (rem_q[WIDTH-1:0]),
      .rmag    (rem_q[RW-1:WIDTH]),
      .q_neg   (qneg_q),
      .r_neg   (rneg_q),
      .zero_div(dz_q),
      .num     (num_q),
      .q_out   (q_fix),
      .r_out   (r_fix)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         rem_q    <= '0;
         dmag_q   <= '0;
         num_q    <= '0;
         qneg_q   <= 1'b0;
         rneg_q   <= 1'b0;
         dz_q     <= 1'b0;
         done_q   <= 1'b0;
         dz_out_q <= 1'b0;
         quot_q   <= '0;
         remd_q   <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  rem_q   <= {{WIDTH{1'b0}}, a_mag};
                  dmag_q  <= d_mag;
                  num_q   <= dividend;
                  qneg_q  <= a_neg ^ d_neg;
                  rneg_q  <= a_neg;
                  dz_q    <= (divisor == '0);
                  cnt_q   <= CW'(WIDTH);
                  state_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               rem_q <= rem_nx;
               cnt_q <= cnt_q - CW'(1);
               if (cnt_q == CW'(1)) state_q <= ST_FIN;
            end
            ST_FIN: begin
               quot_q   <= q_fix;
               remd_q   <= r_fix;
               dz_out_q <= dz_q;
               done_q   <= 1'b1;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (state_q != ST_IDLE);
   assign done        = done_q;
   assign quotient    = quot_q;
   assign remainder   = remd_q;
   assign div_by_zero = dz_out_q;

   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));
   // R7
   zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && div_by_zero) |-> (quotient == '1 && remainder == num_q));
   // R5
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_by_zero) |->
      ((remainder[WIDTH-1] ? (~remainder + WIDTH'(1)) : remainder) < dmag_q));
   // R5
   rem_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_by_zero && remainder != '0) |-> (remainder[WIDTH-1] == num_q[WIDTH-1]));
endmodule

// File: tb/tb_sdiv_top.sv
`timescale 1ns/1ps
module tb_sdiv_top;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] dvd = '0;
   logic [W-1:0] dvs = '0;
   logic         busy, done, dz;
   logic [W-1:0] quo, rem;

   always #2.5 clk = ~clk;

   sdiv_top #(.WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dividend(dvd), .divisor(dvs),
      .busy(busy), .done(done), .quotient(quo), .remainder(rem), .div_by_zero(dz)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit r8_on = 1'b0;

   // behavioural reference model
   bit           m_busy = 0, m_done = 0, m_dz = 0, p_dz = 0;
   int           m_cnt = 0;
   logic [W-1:0] m_q = '0, m_r = '0, p_q = '0, p_r = '0;
   string        m_qtag = "R1", m_rtag = "R1", p_qtag = "R1", p_rtag = "R1";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_dz = 0; m_cnt = 0;
         m_q = '0; m_r = '0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_busy = 0; m_done = 1;
               m_q = p_q; m_r = p_r; m_dz = p_dz;
               m_qtag = p_qtag; m_rtag = p_rtag;
            end
         end else if (start) begin
            longint sa, sd;
            sa = longint'($signed(dvd));
            sd = longint'($signed(dvs));
            m_busy = 1; m_cnt = W + 1;
            if (sd == 0) begin
               p_q = '1; p_r = dvd; p_dz = 1; p_qtag = "R7"; p_rtag = "R7";
            end else begin
               p_q = W'(sa / sd); p_r = W'(sa % sd); p_dz = 0;
               if (dvd == {1'b1, {(W-1){1'b0}}}) begin
                  p_qtag = "R6"; p_rtag = "R6";
               end else if (sa < 0 || sd < 0) begin
                  p_qtag = "R4"; p_rtag = "R5";
               end else begin
                  p_qtag = "R3"; p_rtag = "R3";
               end
            end
            if (r8_on) begin p_qtag = "R8"; p_rtag = "R8"; end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // compare against the model on every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy == m_busy, r8_on ? "R8" : "R2", "busy", longint'(busy), longint'(m_busy));
         chk(done == m_done, "R9", "done", longint'(done), longint'(m_done));
         chk(quo == m_q, m_qtag, "quotient", longint'(quo), longint'(m_q));
         chk(rem == m_r, m_rtag, "remainder", longint'(rem), longint'(m_r));
         chk(dz == m_dz, "R7", "div_by_zero", longint'(dz), longint'(m_dz));
      end
   end

   task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      start = 1'b1; dvd = a; dvs = d;
      @(negedge clk);
      start = 1'b0;
      while (m_busy) @(negedge clk);
   endtask

   localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      lf = 32'h1ACE_B00C;
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(busy == 0 && done == 0 && dz == 0, "R1", "flags in reset", {busy, done, dz}, 0);
      chk(quo == 0 && rem == 0, "R1", "data in reset", longint'(quo ^ rem), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && done == 0 && quo == 0 && rem == 0, "R1", "after reset", longint'(quo), 0);

      // R4 / R5 sign combinations
      do_op(7, 2);
      do_op(7, -2);
      do_op(-7, 2);
      do_op(-7, -2);
      // R3 plain cases
      do_op(0, 5);
      do_op(100, 7);
      do_op(3, 10);
      do_op(MAXV, 1);
      do_op(MAXV, MINV);
      // R6 most negative dividend
      do_op(MINV, 1);
      do_op(MINV, -1);
      do_op(MINV, 2);
      do_op(MINV, MINV);
      // R7 zero divisor
      do_op(5, 0);
      do_op(-5, 0);
      do_op(MINV, 0);

      // R8: a start pulse while busy is ignored
      r8_on = 1'b1;
      @(negedge clk);
      start = 1'b1; dvd = 1000; dvs = -9;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      start = 1'b1; dvd = 12; dvs = 0;
      @(negedge clk);
      start = 1'b0;
      while (m_busy) @(negedge clk);
      r8_on = 1'b0;
      repeat (3) @(negedge clk);

      // mixed-magnitude pseudo-random operands
      for (int i = 0; i < 300; i++) begin
         logic [W-1:0] a, d;
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
         a = lf;
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
         d = W'($signed(lf) >>> (lf[4:0]));
         if (i % 37 == 0) d = '0;
         do_op(a, d);
      end

      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule